// File: doc/BRIEF.md
# White-Balance Statistics Accumulator

This block gathers colour statistics over one video frame to feed an automatic white-balance loop. Every pixel arrives with its red, green and blue samples together with its brightness and saturation. A pixel is admitted only when it is bright enough and close enough to grey. For each admitted pixel the three colour samples are added into separate running sums, and a counter of admitted pixels goes up by one.

A frame-start pulse clears the running sums. A frame-end pulse copies them into result registers, so software always reads the totals of one complete frame and never a partial one. A byte-wide register port sets the two admission limits and reads the results. A read returns data in the same cycle.

Top module: `wb_stat_accum`

## Requirements
- R1: A pixel is admitted only when its brightness `pix_y` is greater than or equal to the brightness floor. A value exactly equal to the floor is admitted.
- R2: A pixel is admitted only when its saturation `pix_s` is less than or equal to the saturation ceiling. A value exactly equal to the ceiling is admitted.
- R3: The brightness floor sits at address 0x00 and resets to 100. The saturation ceiling sits at address 0x01 and resets to 10. Both are 8-bit unsigned registers that can be written and read back.
- R4: The red, green and blue totals are each 24 bits wide. They are read as three bytes at 0x04–0x06 (red), 0x08–0x0A (green) and 0x0C–0x0E (blue). In each group the lowest address holds the least significant byte.
- R5: The admitted-pixel total is 32 bits wide. It is read as four bytes at 0x10–0x13, with 0x13 holding the most significant byte.
- R6: `frm_start` clears all accumulators. `frm_end` copies the accumulators into the result registers, where they can be read from the next cycle. The result registers change at no other time, so a frame in progress does not alter what is read.
- R7: Each accumulator saturates at its all-ones value instead of wrapping around.
- R8: A pixel is counted only in a cycle where `pix_vld` is high, inside a frame. Inside a frame means after the `frm_start` cycle and before the `frm_end` cycle. Pixels in the `frm_start` cycle, in the `frm_end` cycle, or between frames are ignored.
- R9: Writes to result addresses or to unmapped addresses have no effect. Reads from unmapped addresses return 0. All result registers read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_start | input | 1 | One-cycle pulse that opens a frame and clears the accumulators |
| frm_end | input | 1 | One-cycle pulse that closes a frame and latches the results |
| pix_vld | input | 1 | Pixel data is valid this cycle |
| pix_r | input | 8 | Red sample |
| pix_g | input | 8 | Green sample |
| pix_b | input | 8 | Blue sample |
| pix_y | input | 8 | Pixel brightness, unsigned |
| pix_s | input | 8 | Pixel saturation, unsigned |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`, same cycle |

## Verification
The hardest state to reach from the ports is a saturated accumulator. A 24-bit colour sum only stops at its all-ones value after more than 65,793 full-scale samples in a single frame. The stimulus reaches it by streaming 66,000 admitted pixels with red at 255 and green at 1 inside one frame. It then checks that red has stopped at all ones while green and the pixel count still give the exact totals. The boundaries of the frame window are exercised the same way. Admitted pixels are driven on the start and end cycles, between frames, and with the valid signal low, and the count must show none of them.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
    logic [7:0] y;
    logic [7:0] s;
  } wbs_pix_t;

  localparam logic [7:0] A_YFLOOR = 8'h00;
  localparam logic [7:0] A_SCEIL  = 8'h01;
  localparam logic [5:0] SEC_RED  = 6'd1;  // 0x04..0x07
  localparam logic [5:0] SEC_GRN  = 6'd2;  // 0x08..0x0B
  localparam logic [5:0] SEC_BLU  = 6'd3;  // 0x0C..0x0F
  localparam logic [5:0] SEC_CNT  = 6'd4;  // 0x10..0x13

  localparam logic [7:0] YFLOOR_RST = 8'd100;
  localparam logic [7:0] SCEIL_RST  = 8'd10;

  // Dual gate: bright enough and grey enough.
  function automatic logic f_admit(input logic [7:0] y, input logic [7:0] s,
                                   input logic [7:0] yfl, input logic [7:0] sce);
    return (y >= yfl) && (s <= sce);
  endfunction

  // Byte lane i of a 32-bit word.
  function automatic logic [7:0] f_byte(input logic [31:0] w, input logic [1:0] i);
    return w[{3'd0, i} * 8 +: 8];
  endfunction

endpackage

// File: rtl/wbs_gate.sv
module wbs_gate
  import wbs_pkg::*;
(
  input  wbs_pix_t   pix,
  input  logic       vld,
  input  logic       open,
  input  logic [7:0] yfloor,
  input  logic [7:0] sceil,
  output logic       admit
);
  logic pass_thr;
  assign pass_thr = f_admit(pix.y, pix.s, yfloor, sceil);
  assign admit    = vld & open & pass_thr;
endmodule

// File: rtl/wbs_sat_acc.sv
module wbs_sat_acc #(
  parameter int IN_W  = 8,
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add_en,
  input  logic [IN_W-1:0]  inc,
  output logic [ACC_W-1:0] acc
);
  localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};

  logic [ACC_W:0] sum_wide;
  logic           ovf;

  assign sum_wide = {1'b0, acc} + {{(ACC_W + 1 - IN_W){1'b0}}, inc};
  assign ovf      = sum_wide[ACC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (clr)    acc <= '0;
    else if (add_en) acc <= ovf ? ACC_MAX : sum_wide[ACC_W-1:0];
  end

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == '0));

  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && acc == ACC_MAX) |=> (acc == ACC_MAX));

  p_monotonic_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (acc >= $past(acc)));
endmodule

// File: rtl/wbs_regs.sv
module wbs_regs
  import wbs_pkg::*;
#(
  parameter int SUM_W = 24,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latch,
  input  logic [SUM_W-1:0] acc_r,
  input  logic [SUM_W-1:0] acc_g,
  input  logic [SUM_W-1:0] acc_b,
  input  logic [CNT_W-1:0] acc_cnt,
  input  logic [7:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       yfloor,
  output logic [7:0]       sceil,
  output logic [7:0]       reg_rdata
);
  localparam int SUM_BYTES = (SUM_W + 7) / 8;
  localparam int CNT_BYTES = (CNT_W + 7) / 8;

  logic [SUM_W-1:0] res_r, res_g, res_b;
  logic [CNT_W-1:0] res_cnt;
  logic [31:0]      pad_r, pad_g, pad_b, pad_cnt;
  logic [5:0]       sec;
  logic [1:0]       lane;
  logic             lane_sum_ok, lane_cnt_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      yfloor <= YFLOOR_RST;
      sceil  <= SCEIL_RST;
    end else if (reg_wr) begin
      if (reg_addr == A_YFLOOR) yfloor <= reg_wdata;
      if (reg_addr == A_SCEIL)  sceil  <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_r   <= '0;
      res_g   <= '0;
      res_b   <= '0;
      res_cnt <= '0;
    end else if (latch) begin
      res_r   <= acc_r;
      res_g   <= acc_g;
      res_b   <= acc_b;
      res_cnt <= acc_cnt;
    end
  end

  assign pad_r       = 32'(res_r);
  assign pad_g       = 32'(res_g);
  assign pad_b       = 32'(res_b);
  assign pad_cnt     = 32'(res_cnt);
  assign sec         = reg_addr[7:2];
  assign lane        = reg_addr[1:0];
  assign lane_sum_ok = (32'(lane) < SUM_BYTES);
  assign lane_cnt_ok = (32'(lane) < CNT_BYTES);

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == A_YFLOOR)                 reg_rdata = yfloor;
    else if (reg_addr == A_SCEIL)             reg_rdata = sceil;
    else if (sec == SEC_RED && lane_sum_ok)   reg_rdata = f_byte(pad_r, lane);
    else if (sec == SEC_GRN && lane_sum_ok)   reg_rdata = f_byte(pad_g, lane);
    else if (sec == SEC_BLU && lane_sum_ok)   reg_rdata = f_byte(pad_b, lane);
    else if (sec == SEC_CNT && lane_cnt_ok)   reg_rdata = f_byte(pad_cnt, lane);
  end

  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> ($stable(res_cnt) && $stable(res_r) && $stable(res_g) && $stable(res_b)));

  p_latch_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> (res_cnt == $past(acc_cnt)));

  p_floor_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_YFLOOR) |=> (yfloor == $past(reg_wdata)));

  p_thr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr || reg_addr > A_SCEIL) |=> ($stable(yfloor) && $stable(sceil)));
endmodule

// File: rtl/wb_stat_accum.sv
module wb_stat_accum
  import wbs_pkg::*;
#(
  parameter int SUM_W = 24,
  parameter int CNT_W = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frm_start,
  input  logic       frm_end,
  input  logic       pix_vld,
  input  logic [7:0] pix_r,
  input  logic [7:0] pix_g,
  input  logic [7:0] pix_b,
  input  logic [7:0] pix_y,
  input  logic [7:0] pix_s,
  input  logic [7:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);
  localparam int NCH = 3;

  wbs_pix_t         pix;
  logic             in_frame, win_open, admit, latch;
  logic [7:0]       yfloor, sceil;
  logic [7:0]       ch_in  [NCH];
  logic [SUM_W-1:0] ch_acc [NCH];
  logic [CNT_W-1:0] cnt_acc;

  assign pix      = '{r: pix_r, g: pix_g, b: pix_b, y: pix_y, s: pix_s};
  assign ch_in[0] = pix_r;
  assign ch_in[1] = pix_g;
  assign ch_in[2] = pix_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         in_frame <= 1'b0;
    else if (frm_end)   in_frame <= 1'b0;
    else if (frm_start) in_frame <= 1'b1;
  end

  assign win_open = in_frame & ~frm_start & ~frm_end;
  assign latch    = frm_end & in_frame;

  wbs_gate u_gate (
    .pix    (pix),
    .vld    (pix_vld),
    .open   (win_open),
    .yfloor (yfloor),
    .sceil  (sceil),
    .admit  (admit)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    wbs_sat_acc #(.IN_W(8), .ACC_W(SUM_W)) u_sum (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (frm_start),
      .add_en (admit),
      .inc    (ch_in[c]),
      .acc    (ch_acc[c])
    );
  end

  wbs_sat_acc #(.IN_W(1), .ACC_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (frm_start),
    .add_en (admit),
    .inc    (1'b1),
    .acc    (cnt_acc)
  );

  wbs_regs #(.SUM_W(SUM_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .latch     (latch),
    .acc_r     (ch_acc[0]),
    .acc_g     (ch_acc[1]),
    .acc_b     (ch_acc[2]),
    .acc_cnt   (cnt_acc),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .yfloor    (yfloor),
    .sceil     (sceil),
    .reg_rdata (reg_rdata)
  );

  p_floor_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_acc != $past(cnt_acc) && !$past(frm_start)) |-> ($past(pix_y) >= $past(yfloor)));

  p_ceiling_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_acc != $past(cnt_acc) && !$past(frm_start)) |-> ($past(pix_s) <= $past(sceil)));

  p_outside_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((!pix_vld || !in_frame || frm_end) && !frm_start) |=> $stable(cnt_acc));
endmodule

// File: tb/test_wb_stat_accum.sv
module test_wb_stat_accum;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frm_start = 1'b0, frm_end = 1'b0, pix_vld = 1'b0;
  logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0, pix_y = '0, pix_s = '0;
  logic [7:0] reg_addr = '0, reg_wdata = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  wb_stat_accum i_wb_stat_accum (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_end(frm_end),
    .pix_vld(pix_vld), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .pix_y(pix_y), .pix_s(pix_s), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // {y, s, r, g, b, admitted} with floor 100 and ceiling 10
  localparam int NV = 12;
  localparam logic [40:0] VEC [NV] = '{
    {8'd100, 8'd10,  8'd11, 8'd22, 8'd33, 1'b1},
    {8'd99,  8'd10,  8'd40, 8'd41, 8'd42, 1'b0},
    {8'd100, 8'd11,  8'd50, 8'd51, 8'd52, 1'b0},
    {8'd255, 8'd0,   8'd255,8'd1,  8'd128,1'b1},
    {8'd0,   8'd0,   8'd9,  8'd9,  8'd9,  1'b0},
    {8'd200, 8'd255, 8'd70, 8'd71, 8'd72, 1'b0},
    {8'd101, 8'd9,   8'd5,  8'd6,  8'd7,  1'b1},
    {8'd255, 8'd10,  8'd90, 8'd0,  8'd200,1'b1},
    {8'd100, 8'd0,   8'd0,  8'd254,8'd1,  1'b1},
    {8'd50,  8'd50,  8'd60, 8'd61, 8'd62, 1'b0},
    {8'd128, 8'd5,   8'd17, 8'd18, 8'd19, 1'b1},
    {8'd99,  8'd11,  8'd80, 8'd81, 8'd82, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #2;
    d = reg_rdata;
  endtask

  task automatic rd_word(input logic [7:0] base, input int nb, output logic [31:0] w);
    logic [7:0] d;
    w = '0;
    for (int i = 0; i < nb; i++) begin
      rd(base + 8'(i), d);
      w[i*8 +: 8] = d;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_pix(input logic [7:0] y, s, r, g, b);
    pix_y = y; pix_s = s; pix_r = r; pix_g = g; pix_b = b;
  endtask

  task automatic run_frame(input int n, input logic [7:0] y, s, r, g, b);
    @(negedge clk) frm_start = 1'b1;
    @(negedge clk) frm_start = 1'b0;
    set_pix(y, s, r, g, b);
    pix_vld = 1'b1;
    repeat (n) @(negedge clk);
    pix_vld = 1'b0;
    frm_end = 1'b1;
    @(negedge clk) frm_end = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic [7:0]  d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state
    rd(8'h00, d); chk("R3 floor reset", 32'(d), 32'd100);
    rd(8'h01, d); chk("R3 ceiling reset", 32'(d), 32'd10);
    rd_word(8'h10, 4, w); chk("R9 count after reset", w, 32'd0);
    rd_word(8'h04, 3, w); chk("R9 red after reset", w, 32'd0);

    // Vector table: one frame per pixel
    for (int i = 0; i < NV; i++) begin
      logic [40:0] v;
      logic        q;
      v = VEC[i];
      q = v[0];
      run_frame(1, v[40:33], v[32:25], v[24:17], v[16:9], v[8:1]);
      rd_word(8'h10, 4, w); chk("R1/R2 admit count", w, 32'(q));
      rd_word(8'h04, 3, w); chk("R4 red single", w, q ? 32'(v[24:17]) : 32'd0);
      rd_word(8'h08, 3, w); chk("R4 green single", w, q ? 32'(v[16:9]) : 32'd0);
      rd_word(8'h0C, 3, w); chk("R4 blue single", w, q ? 32'(v[8:1]) : 32'd0);
    end

    // R3: new thresholds, boundaries at the new values
    wr(8'h00, 8'd50);
    wr(8'h01, 8'd60);
    rd(8'h00, d); chk("R3 floor readback", 32'(d), 32'd50);
    rd(8'h01, d); chk("R3 ceiling readback", 32'(d), 32'd60);
    run_frame(1, 8'd50, 8'd60, 8'd3, 8'd3, 8'd3);
    rd_word(8'h10, 4, w); chk("R1 new floor equal admitted", w, 32'd1);
    run_frame(1, 8'd49, 8'd0, 8'd3, 8'd3, 8'd3);
    rd_word(8'h10, 4, w); chk("R1 below new floor rejected", w, 32'd0);
    run_frame(1, 8'd255, 8'd61, 8'd3, 8'd3, 8'd3);
    rd_word(8'h10, 4, w); chk("R2 above new ceiling rejected", w, 32'd0);
    wr(8'h00, 8'd100);
    wr(8'h01, 8'd10);

    // R4/R5: multi-byte totals, byte order
    run_frame(300, 8'd200, 8'd0, 8'd255, 8'd128, 8'd7);
    rd(8'h04, d); chk("R4 red byte0", 32'(d), 32'hD4);
    rd(8'h05, d); chk("R4 red byte1", 32'(d), 32'h2A);
    rd(8'h06, d); chk("R4 red byte2", 32'(d), 32'h01);
    rd_word(8'h08, 3, w); chk("R4 green", w, 32'd38400);
    rd_word(8'h0C, 3, w); chk("R4 blue", w, 32'd2100);
    rd(8'h10, d); chk("R5 count byte0", 32'(d), 32'h2C);
    rd(8'h11, d); chk("R5 count byte1", 32'(d), 32'h01);
    rd(8'h13, d); chk("R5 count byte3", 32'(d), 32'h00);

    // R9: writes to result and unmapped addresses ignored
    wr(8'h10, 8'hFF);
    wr(8'h06, 8'hFF);
    wr(8'h02, 8'h55);
    rd(8'h10, d); chk("R9 count write ignored", 32'(d), 32'h2C);
    rd(8'h06, d); chk("R9 red write ignored", 32'(d), 32'h01);
    rd(8'h02, d); chk("R9 unmapped reads zero", 32'(d), 32'h00);
    rd(8'h07, d); chk("R9 pad lane reads zero", 32'(d), 32'h00);
    rd(8'h00, d); chk("R9 floor untouched", 32'(d), 32'd100);

    // R8: pixels outside the frame window or not valid
    set_pix(8'd200, 8'd0, 8'd1, 8'd1, 8'd1);
    @(negedge clk) pix_vld = 1'b1;           // between frames
    repeat (5) @(negedge clk);
    frm_start = 1'b1;                         // valid pixel on start cycle
    @(negedge clk) frm_start = 1'b0;
    repeat (2) @(negedge clk);                // two counted pixels
    pix_vld = 1'b0;                           // admitted data, not valid
    repeat (3) @(negedge clk);
    pix_vld = 1'b1; frm_end = 1'b1;           // valid pixel on end cycle
    @(negedge clk) frm_end = 1'b0;
    repeat (4) @(negedge clk);                // between frames again
    pix_vld = 1'b0;
    rd_word(8'h10, 4, w); chk("R8 only in-frame valid pixels", w, 32'd2);

    // R6: a frame in progress leaves results alone; start clears
    @(negedge clk) frm_start = 1'b1;
    @(negedge clk) frm_start = 1'b0;
    pix_vld = 1'b1;
    repeat (7) @(negedge clk);
    pix_vld = 1'b0;
    rd_word(8'h10, 4, w); chk("R6 result stable mid-frame", w, 32'd2);
    @(negedge clk) frm_end = 1'b1;
    @(negedge clk) frm_end = 1'b0;
    rd_word(8'h10, 4, w); chk("R6 new frame latched, cleared at start", w, 32'd7);

    // R7: saturation of the red sum
    run_frame(66000, 8'd200, 8'd0, 8'd255, 8'd1, 8'd0);
    rd_word(8'h04, 3, w); chk("R7 red saturated", w, 32'hFFFFFF);
    rd_word(8'h08, 3, w); chk("R7 green exact", w, 32'd66000);
    rd_word(8'h10, 4, w); chk("R7 count exact", w, 32'd66000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule